// File: doc/BRIEF.md
# Cache Flush Request Sequencer

This block turns an active-low external flush request into a complete, ordered cleaning of two small caches. The request input is checked on every clock, and a high-to-low transition is recorded as a pending event. The pending event waits for an instruction-boundary strobe and is not acted on in the middle of an instruction. When servicing begins, a line walker steps through every data-cache line. Each modified line goes out through a write-back request/grant handshake, and each data line is then invalidated. The walker next steps through every instruction-cache line and invalidates it. Last, it issues one flush-acknowledge special cycle.

Three control inputs (stop-clock, init and a debug-ready input) block the capture of request edges while any of them is active. Edges that arrive during that time are lost. If the request input is low on the first clock after reset is released, the block latches a float-test flag and does not queue a flush. The per-line valid and modified bits are held inside the block. A simple fill port marks lines as valid or modified, and the bits are visible at the outputs.

Top module: `flush_seq_top`

## Requirements
- R1: After reset, busy, ack_cycle, wb_req and float_test are 0, cycle_type is 3'b000, and every bit of dc_valid, dc_dirty and ic_valid is 0.
- R2: Only a high-to-low transition of flush_n marks a flush as pending. Holding flush_n low after the flush it triggered has been serviced starts no further flush.
- R3: A pending flush starts only on a clock where insn_boundary is 1 and the block is idle. busy goes to 1 on the clock after that edge. With insn_boundary held at 0, a pending flush never starts.
- R4: An edge of flush_n that occurs while stop_clk, init_in or prdy_in is 1 is ignored. It gives no flush even after the blocking input returns to 0 and insn_boundary pulses.
- R5: Modified data lines are written back in ascending index order. wb_req is 1 with wb_idx equal to the line index, and it holds with a stable index until a clock where wb_ack is 1. After that the line's valid and dirty bits are 0. Unmodified lines produce no wb_req.
- R6: When ack_cycle is 1, every bit of dc_valid, dc_dirty and ic_valid is 0.
- R7: Each serviced flush gives exactly one ack_cycle pulse, one clock long. While ack_cycle is 1, cycle_type is 3'b011; at all other times it is 3'b000.
- R8: busy stays 1 from the clock after service starts up to and including the ack_cycle clock. busy is 0 on the clock after the ack_cycle clock unless another flush starts at that same edge.
- R9: A high-to-low transition of flush_n while busy is 1 leaves exactly one further flush pending. That flush starts at the next instruction boundary after the current flush ends.
- R10: If flush_n is 0 on the first clock after rst_n rises, float_test becomes 1 and no flush is queued. float_test then stays 1 until the next reset.
- R11: A fill (fill_en=1, fill_icache selects the instruction cache when 1, line fill_idx, fill_dirty marks a data line as modified) takes effect only while busy is 0. Fills presented while busy is 1 are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_n | input | 1 | Active-low flush request; its falling edge is the event |
| insn_boundary | input | 1 | Strobe marking an instruction boundary |
| stop_clk | input | 1 | Stop-clock state; blocks edge capture |
| init_in | input | 1 | Init request; blocks edge capture |
| prdy_in | input | 1 | Debug-ready indication; blocks edge capture |
| fill_en | input | 1 | Mark a line valid |
| fill_icache | input | 1 | 1 selects the instruction cache, 0 the data cache |
| fill_idx | input | 3 | Line index for the fill |
| fill_dirty | input | 1 | Mark the filled data line as modified |
| wb_ack | input | 1 | Grant for the current write-back |
| wb_req | output | 1 | Write-back request for a modified data line |
| wb_idx | output | 3 | Line index of the write-back |
| busy | output | 1 | A flush is being serviced |
| ack_cycle | output | 1 | One-clock flush-acknowledge special cycle |
| cycle_type | output | 3 | Special-cycle code, 3'b011 during ack_cycle |
| float_test | output | 1 | Float-test mode selected at reset release |
| dc_valid | output | 8 | Data-cache valid bits, one per line |
| dc_dirty | output | 8 | Data-cache modified bits, one per line |
| ic_valid | output | 8 | Instruction-cache valid bits, one per line |

## Verification
The write-back properties assume wb_ack is raised only while wb_req is 1. The stimulus grants a request only after it has seen one, and it can add a chosen number of wait clocks first. The properties also assume every input is synchronous to clk. The bench changes all inputs on the falling clock edge, fills lines only while the block is idle, and pulses the blocking inputs around flush_n edges that it places on purpose, so that each blocking window covers the edge under test.

// File: rtl/flush_seq_pkg.sv
package flush_seq_pkg;

  typedef enum logic [2:0] {
    W_IDLE  = 3'd0,
    W_DSCAN = 3'd1,
    W_DWB   = 3'd2,
    W_ISCAN = 3'd3,
    W_ACK   = 3'd4
  } walk_state_t;

  localparam logic [2:0] CYC_NONE      = 3'b000;
  localparam logic [2:0] CYC_FLUSH_ACK = 3'b011;

endpackage

// File: rtl/flush_edge_latch.sv
module flush_edge_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic flush_n,
  input  logic stop_clk,
  input  logic init_in,
  input  logic prdy_in,
  input  logic start,
  output logic pending,
  output logic float_test
);

  logic prev_q, prev_d;
  logic armed_q, armed_d;
  logic pend_q, pend_d;
  logic float_q, float_d;
  logic samp_en, fall;

  always_comb begin
    samp_en = ~stop_clk & ~init_in & ~prdy_in;
    fall    = armed_q & samp_en & prev_q & ~flush_n;
    prev_d  = flush_n;
    armed_d = 1'b1;
    float_d = float_q | (~armed_q & ~flush_n);
    pend_d  = fall | (pend_q & ~start);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b1;
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
      float_q <= 1'b0;
    end else begin
      prev_q  <= prev_d;
      armed_q <= armed_d;
      pend_q  <= pend_d;
      float_q <= float_d;
    end
  end

  assign pending    = pend_q;
  assign float_test = float_q;

endmodule

// File: rtl/cache_line_bits.sv
module cache_line_bits #(
  parameter int LINES     = 8,
  parameter int IDX_W     = 3,
  parameter bit HAS_DIRTY = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             set_dirty,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  output logic [LINES-1:0] valid,
  output logic [LINES-1:0] dirty
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic hit_set, hit_clr, v_en, v_d, v_q;

    always_comb begin
      hit_set = set_en & (set_idx == IDX_W'(g));
      hit_clr = clr_en & (clr_idx == IDX_W'(g));
      v_en    = hit_set | hit_clr;
      v_d     = hit_clr ? 1'b0 : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    v_q <= 1'b0;
      else if (v_en) v_q <= v_d;
    end
    assign valid[g] = v_q;

    if (HAS_DIRTY) begin : g_dirty
      logic d_en, d_d, d_q;
      always_comb begin
        d_en = hit_set | hit_clr;
        d_d  = hit_clr ? 1'b0 : set_dirty;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    d_q <= 1'b0;
        else if (d_en) d_q <= d_d;
      end
      assign dirty[g] = d_q;
    end else begin : g_nodirty
      assign dirty[g] = 1'b0;
    end
  end

  if (!HAS_DIRTY) begin : g_tie
    logic unused_dirty_in;
    assign unused_dirty_in = set_dirty;
  end

endmodule

// File: rtl/flush_walker.sv
module flush_walker
  import flush_seq_pkg::*;
#(
  parameter int LINES = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pending,
  input  logic             insn_boundary,
  input  logic [LINES-1:0] dc_dirty,
  input  logic             wb_ack,
  output logic             start,
  output logic             busy,
  output logic             wb_req,
  output logic [IDX_W-1:0] wb_idx,
  output logic             dc_clr_en,
  output logic             ic_clr_en,
  output logic [IDX_W-1:0] clr_idx,
  output logic             ack_cycle,
  output logic [2:0]       cycle_type
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINES - 1);

  walk_state_t      state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en, last;

  always_comb begin
    state_d    = state_q;
    idx_d      = idx_q;
    idx_en     = 1'b0;
    wb_req     = 1'b0;
    dc_clr_en  = 1'b0;
    ic_clr_en  = 1'b0;
    ack_cycle  = 1'b0;
    cycle_type = CYC_NONE;
    last       = (idx_q == LAST_IDX);
    start      = pending & insn_boundary & (state_q == W_IDLE);

    unique case (state_q)
      W_IDLE: begin
        if (start) begin
          state_d = W_DSCAN;
          idx_d   = '0;
          idx_en  = 1'b1;
        end
      end
      W_DSCAN: begin
        if (dc_dirty[idx_q]) begin
          state_d = W_DWB;
        end else begin
          dc_clr_en = 1'b1;
          idx_en    = 1'b1;
          if (last) begin
            state_d = W_ISCAN;
            idx_d   = '0;
          end else begin
            idx_d   = idx_q + 1'b1;
          end
        end
      end
      W_DWB: begin
        wb_req = 1'b1;
        if (wb_ack) begin
          dc_clr_en = 1'b1;
          idx_en    = 1'b1;
          if (last) begin
            state_d = W_ISCAN;
            idx_d   = '0;
          end else begin
            state_d = W_DSCAN;
            idx_d   = idx_q + 1'b1;
          end
        end
      end
      W_ISCAN: begin
        ic_clr_en = 1'b1;
        if (last) begin
          state_d = W_ACK;
        end else begin
          idx_d  = idx_q + 1'b1;
          idx_en = 1'b1;
        end
      end
      W_ACK: begin
        ack_cycle  = 1'b1;
        cycle_type = CYC_FLUSH_ACK;
        state_d    = W_IDLE;
      end
      default: state_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= W_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (idx_en) idx_q <= idx_d;
    end
  end

  assign busy    = (state_q != W_IDLE);
  assign wb_idx  = idx_q;
  assign clr_idx = idx_q;

endmodule

// File: rtl/flush_seq_top.sv
module flush_seq_top #(
  parameter int LINES = 8,
  parameter int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_n,
  input  logic             insn_boundary,
  input  logic             stop_clk,
  input  logic             init_in,
  input  logic             prdy_in,
  input  logic             fill_en,
  input  logic             fill_icache,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic             fill_dirty,
  input  logic             wb_ack,
  output logic             wb_req,
  output logic [IDX_W-1:0] wb_idx,
  output logic             busy,
  output logic             ack_cycle,
  output logic [2:0]       cycle_type,
  output logic             float_test,
  output logic [LINES-1:0] dc_valid,
  output logic [LINES-1:0] dc_dirty,
  output logic [LINES-1:0] ic_valid
);

  logic             pending, start;
  logic             dc_clr_en, ic_clr_en;
  logic [IDX_W-1:0] clr_idx;
  logic             dc_set, ic_set;
  logic [LINES-1:0] ic_dirty_nc;

  assign dc_set = fill_en & ~busy & ~fill_icache;
  assign ic_set = fill_en & ~busy &  fill_icache;

  flush_edge_latch u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush_n    (flush_n),
    .stop_clk   (stop_clk),
    .init_in    (init_in),
    .prdy_in    (prdy_in),
    .start      (start),
    .pending    (pending),
    .float_test (float_test)
  );

  flush_walker #(.LINES(LINES), .IDX_W(IDX_W)) u_walk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pending       (pending),
    .insn_boundary (insn_boundary),
    .dc_dirty      (dc_dirty),
    .wb_ack        (wb_ack),
    .start         (start),
    .busy          (busy),
    .wb_req        (wb_req),
    .wb_idx        (wb_idx),
    .dc_clr_en     (dc_clr_en),
    .ic_clr_en     (ic_clr_en),
    .clr_idx       (clr_idx),
    .ack_cycle     (ack_cycle),
    .cycle_type    (cycle_type)
  );

  cache_line_bits #(.LINES(LINES), .IDX_W(IDX_W), .HAS_DIRTY(1'b1)) u_dbits (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_en    (dc_set),
    .set_idx   (fill_idx),
    .set_dirty (fill_dirty),
    .clr_en    (dc_clr_en),
    .clr_idx   (clr_idx),
    .valid     (dc_valid),
    .dirty     (dc_dirty)
  );

  cache_line_bits #(.LINES(LINES), .IDX_W(IDX_W), .HAS_DIRTY(1'b0)) u_ibits (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_en    (ic_set),
    .set_idx   (fill_idx),
    .set_dirty (fill_dirty),
    .clr_en    (ic_clr_en),
    .clr_idx   (clr_idx),
    .valid     (ic_valid),
    .dirty     (ic_dirty_nc)
  );

  logic unused_ic_dirty;
  assign unused_ic_dirty = |ic_dirty_nc;

endmodule

// File: rtl/flush_seq_chk.sv
module flush_seq_chk
  import flush_seq_pkg::*;
#(
  parameter int LINES = 8,
  parameter int IDX_W = $clog2(LINES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             insn_boundary,
  input logic             wb_ack,
  input logic             wb_req,
  input logic [IDX_W-1:0] wb_idx,
  input logic             busy,
  input logic             ack_cycle,
  input logic [2:0]       cycle_type,
  input logic [LINES-1:0] dc_valid,
  input logic [LINES-1:0] dc_dirty,
  input logic [LINES-1:0] ic_valid
);

  assert_start_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(insn_boundary));

  assert_wb_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && !wb_ack) |=> (wb_req && $stable(wb_idx)));

  assert_wb_dirty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> dc_dirty[wb_idx]);

  assert_ack_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_cycle |-> (dc_valid == '0 && dc_dirty == '0 && ic_valid == '0));

  assert_ack_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_cycle |=> !ack_cycle);

  assert_ack_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_cycle |-> (cycle_type == CYC_FLUSH_ACK));

  assert_idle_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_cycle |-> (cycle_type == CYC_NONE));

  assert_ack_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_cycle |-> busy);

  assert_busy_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_cycle && !insn_boundary) |=> !busy);

endmodule

bind flush_seq_top flush_seq_chk #(.LINES(LINES), .IDX_W(IDX_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .insn_boundary (insn_boundary),
  .wb_ack        (wb_ack),
  .wb_req        (wb_req),
  .wb_idx        (wb_idx),
  .busy          (busy),
  .ack_cycle     (ack_cycle),
  .cycle_type    (cycle_type),
  .dc_valid      (dc_valid),
  .dc_dirty      (dc_dirty),
  .ic_valid      (ic_valid)
);

// File: tb/tb_flush_seq_top.sv
module tb_flush_seq_top;

  logic       clk = 1'b0;
  logic       rst_n, flush_n, insn_boundary, stop_clk, init_in, prdy_in;
  logic       fill_en, fill_icache, fill_dirty, wb_ack;
  logic [2:0] fill_idx;
  logic       wb_req, busy, ack_cycle, float_test;
  logic [2:0] wb_idx, cycle_type;
  logic [7:0] dc_valid, dc_dirty, ic_valid;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  flush_seq_top dut (
    .clk(clk), .rst_n(rst_n), .flush_n(flush_n), .insn_boundary(insn_boundary),
    .stop_clk(stop_clk), .init_in(init_in), .prdy_in(prdy_in),
    .fill_en(fill_en), .fill_icache(fill_icache), .fill_idx(fill_idx),
    .fill_dirty(fill_dirty), .wb_ack(wb_ack), .wb_req(wb_req), .wb_idx(wb_idx),
    .busy(busy), .ack_cycle(ack_cycle), .cycle_type(cycle_type),
    .float_test(float_test), .dc_valid(dc_valid), .dc_dirty(dc_dirty),
    .ic_valid(ic_valid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset(input logic flush_lvl);
    rst_n = 1'b0; flush_n = flush_lvl; insn_boundary = 1'b0;
    stop_clk = 1'b0; init_in = 1'b0; prdy_in = 1'b0;
    fill_en = 1'b0; fill_icache = 1'b0; fill_idx = '0; fill_dirty = 1'b0;
    wb_ack = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic fill(input logic ic, input int idx, input logic dirty);
    fill_en = 1'b1; fill_icache = ic; fill_idx = 3'(idx); fill_dirty = dirty;
    tick();
    fill_en = 1'b0; fill_dirty = 1'b0;
  endtask

  task automatic pulse_boundary();
    insn_boundary = 1'b1;
    tick();
    insn_boundary = 1'b0;
  endtask

  // Services write-backs with 'delay' wait clocks and checks order, ack and busy.
  task automatic run_flush(input logic [7:0] dmask, input int delay, input logic busy_after);
    int  last_idx = -1;
    int  waited   = 0;
    int  acks     = 0;
    bit  done     = 0;
    for (int c = 0; c < 400 && !done; c++) begin
      if (ack_cycle) begin
        acks++;
        check(dc_valid == 8'h00 && dc_dirty == 8'h00 && ic_valid == 8'h00, "R6 caches clean at ack",
              {dc_valid, dc_dirty, ic_valid}, 0);
        check(cycle_type == 3'b011, "R7 ack cycle code", cycle_type, 3'b011);
        check(busy == 1'b1, "R8 busy during ack", busy, 1);
        done = 1;
        wb_ack = 1'b0;
      end else begin
        check(cycle_type == 3'b000, "R7 idle cycle code", cycle_type, 0);
        if (wb_req) begin
          if (waited >= delay) begin
            int exp = -1;
            for (int k = last_idx + 1; k < 8 && exp < 0; k++) if (dmask[k]) exp = k;
            check(int'(wb_idx) == exp, "R5 write-back order", wb_idx, exp);
            last_idx = int'(wb_idx);
            wb_ack = 1'b1;
            waited = 0;
          end else begin
            wb_ack = 1'b0;
            waited++;
          end
        end else begin
          wb_ack = 1'b0;
          waited = 0;
        end
      end
      tick();
    end
    wb_ack = 1'b0;
    check(acks == 1, "R7 one ack per flush", acks, 1);
    begin
      int exp_last = -1;
      for (int k = 0; k < 8; k++) if (dmask[k]) exp_last = k;
      check(last_idx == exp_last, "R5 all modified lines written back", last_idx, exp_last);
    end
    check(busy == busy_after, "R8 busy after ack", busy, busy_after);
  endtask

  task automatic t_reset();
    do_reset(1'b1);
    check(!busy && !ack_cycle && !wb_req && !float_test && cycle_type == 3'b000,
          "R1 reset outputs", {busy, ack_cycle, wb_req, float_test}, 0);
    check(dc_valid == 0 && dc_dirty == 0 && ic_valid == 0, "R1 reset cache bits",
          {dc_valid, dc_dirty, ic_valid}, 0);
  endtask

  task automatic t_basic_flush();
    fill(1'b0, 1, 1'b1); fill(1'b0, 3, 1'b0); fill(1'b0, 6, 1'b1);
    fill(1'b1, 0, 1'b0); fill(1'b1, 7, 1'b1);
    check(dc_valid == 8'h4A && dc_dirty == 8'h42 && ic_valid == 8'h81, "R11 fills while idle",
          {dc_valid, dc_dirty, ic_valid}, 24'h4A4281);
    flush_n = 1'b0;
    repeat (6) tick();
    check(busy == 1'b0, "R3 no start without boundary", busy, 0);
    pulse_boundary();
    check(busy == 1'b1, "R3 start after boundary", busy, 1);
    run_flush(8'h42, 2, 1'b0);
    repeat (3) pulse_boundary();
    check(busy == 1'b0, "R2 held low level does not retrigger", busy, 0);
    flush_n = 1'b1;
    tick();
  endtask

  task automatic t_all_dirty();
    for (int i = 0; i < 8; i++) fill(1'b0, i, 1'b1);
    for (int i = 0; i < 8; i++) fill(1'b1, i, 1'b0);
    flush_n = 1'b0;
    tick();
    flush_n = 1'b1;
    pulse_boundary();
    check(busy == 1'b1, "R2 falling edge queues flush", busy, 1);
    run_flush(8'hFF, 0, 1'b0);
  endtask

  task automatic t_gate(input int which);
    fill(1'b0, 2, 1'b0);
    case (which)
      0: stop_clk = 1'b1;
      1: init_in  = 1'b1;
      default: prdy_in = 1'b1;
    endcase
    tick();
    flush_n = 1'b0;
    repeat (2) tick();
    stop_clk = 1'b0; init_in = 1'b0; prdy_in = 1'b0;
    tick();
    pulse_boundary();
    tick();
    check(busy == 1'b0 && dc_valid == 8'h04, "R4 blocked edge ignored", {busy, dc_valid}, 9'h004);
    flush_n = 1'b1;
    tick();
    flush_n = 1'b0;
    tick();
    pulse_boundary();
    check(busy == 1'b1, "R4 edge after block accepted", busy, 1);
    run_flush(8'h00, 0, 1'b0);
    flush_n = 1'b1;
    tick();
  endtask

  task automatic t_rearm();
    fill(1'b0, 0, 1'b1);
    flush_n = 1'b0;
    tick();
    pulse_boundary();
    check(busy == 1'b1, "R9 first flush started", busy, 1);
    flush_n = 1'b1;
    tick();
    fill(1'b0, 5, 1'b1);
    flush_n = 1'b0;
    tick();
    flush_n = 1'b1;
    run_flush(8'h01, 1, 1'b0);
    check(dc_valid == 8'h00, "R11 fill while busy dropped", dc_valid, 0);
    pulse_boundary();
    check(busy == 1'b1, "R9 re-armed flush starts", busy, 1);
    run_flush(8'h00, 0, 1'b0);
    repeat (2) pulse_boundary();
    check(busy == 1'b0, "R9 only one extra flush", busy, 0);
  endtask

  task automatic t_float();
    do_reset(1'b0);
    check(float_test == 1'b1, "R10 float test selected", float_test, 1);
    repeat (2) pulse_boundary();
    check(busy == 1'b0, "R10 no flush queued at reset", busy, 0);
    flush_n = 1'b1;
    tick();
    flush_n = 1'b0;
    tick();
    pulse_boundary();
    check(busy == 1'b1, "R10 later edge flushes", busy, 1);
    run_flush(8'h00, 0, 1'b0);
    check(float_test == 1'b1, "R10 float test held", float_test, 1);
    do_reset(1'b1);
    check(float_test == 1'b0, "R10 cleared by reset", float_test, 0);
  endtask

  initial begin
    t_reset();
    t_basic_flush();
    t_all_dirty();
    t_gate(0);
    t_gate(1);
    t_gate(2);
    t_rearm();
    t_float();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule